// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is the control unit of a small accumulator processor with five instructions. It does not decode the opcode with gates. The opcode is captured into a micro-address register. That register indexes a store that holds five 11-bit control words. The selected word is then latched into a buffer register, and the buffer register drives the datapath load and enable lines for one execute cycle. In every other cycle the block presents a fixed fetch control word, which steps the program counter and loads the instruction register.

The surrounding datapath raises a one-cycle fetch-done strobe once the instruction register holds a new instruction, and puts the opcode alongside it. A halt microword stops the sequencer: from then on every control line stays low until reset.

Control bit assignment, from bit 0 upward: PC increment, PC-to-MAR, IR address field to MAR, RAM read, IR load, accumulator load from the bus, add/subtract select (1 = subtract), ALU result to accumulator, operand register load, output register load, halt.

Top module: `ucode_sequencer`

## Requirements
- R1: While reset is high and in the first cycle after it, `ctrl` equals the fetch word 0x01B and `halted` is 0.
- R2: While not halted and not executing, `ctrl` holds the fetch word 0x01B (bits 0, 1, 3 and 4 set: PC increment, PC-to-MAR, RAM read, IR load).
- R3: The opcodes map to these microwords: 0000 gives 0x02C (load), 0001 gives 0x18C (add), 0010 gives 0x1CC (subtract), 1110 gives 0x200 (output) and 1111 gives 0x400 (halt).
- R4: If `fetch_done` is high at clock edge k, `ctrl` shows the fetch word after edge k, shows the microword after edge k+1 for exactly one cycle, and shows the fetch word again after edge k+2.
- R5: An opcode outside the five supported values yields an all-zero control word in its execute cycle, and the sequencer then returns to fetch.
- R6: A `fetch_done` strobe at edge k+1 or k+2 (during the pending or execute cycle of an accepted instruction) is ignored. The next instruction is accepted no earlier than edge k+3.
- R7: After the halt microword's execute cycle, `halted` is 1 and `ctrl` is all zero until reset, and `fetch_done` strobes are ignored.
- R8: A datapath that obeys the control bits, running the program load 9h, add Ah, add Bh, subtract Ch, output, halt over memory values 10h, 14h, 18h and 20h, ends with 1Ch in its output register.
- R9: Reset after a halt restores the fetch word, clears `halted`, and lets instructions run again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | OP_W (4) | Opcode field of the instruction register |
| fetch_done | input | 1 | One-cycle strobe: a new instruction is ready |
| ctrl | output | CW_W (11) | Control word to the datapath |
| halted | output | 1 | High once a halt microword has executed |

## Verification
The bench builds the sequencer with its default widths: an 11-bit control word and a 4-bit opcode. With these widths, every supported opcode can be driven, and so can unsupported values such as 0101 and 0111, and the halt bit sits in the top position. A cycle-level scoreboard covers the pending, execute and return-to-fetch cycles of each instruction, strobes held high across those cycles, and the behaviour after halt and after a fresh reset. A small behavioural accumulator model interprets the control bits, so the full program can be run and its 1Ch result checked.

// File: rtl/ucode_sequencer.sv
module ucode_sequencer #(
  parameter int CW_W = 11,
  parameter int OP_W = 4,
  parameter int ENTRIES = 5,
  parameter logic [CW_W-1:0] FETCH_WORD = CW_W'(11'h01B)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] opcode,
  input  logic            fetch_done,
  output logic [CW_W-1:0] ctrl,
  output logic            halted
);
  localparam int IDX_W = $clog2(ENTRIES);

  function automatic logic [CW_W-1:0] init_word(input int i);
    case (i)
      0: init_word = CW_W'(11'h02C);
      1: init_word = CW_W'(11'h18C);
      2: init_word = CW_W'(11'h1CC);
      3: init_word = CW_W'(11'h200);
      4: init_word = CW_W'(11'h400);
      default: init_word = '0;
    endcase
  endfunction

  logic [CW_W-1:0] ustore [ENTRIES];
  for (genvar g = 0; g < ENTRIES; g++) begin : g_store
    assign ustore[g] = init_word(g);
  end

  logic [OP_W-1:0]  uaddr_q;
  logic [CW_W-1:0]  buf_q;
  logic             pend_q, exec_q, halt_q;
  logic [IDX_W-1:0] idx;
  logic             hit;

  always_comb begin
    hit = 1'b1;
    case (uaddr_q)
      OP_W'(4'h0): idx = IDX_W'(0);
      OP_W'(4'h1): idx = IDX_W'(1);
      OP_W'(4'h2): idx = IDX_W'(2);
      OP_W'(4'hE): idx = IDX_W'(3);
      OP_W'(4'hF): idx = IDX_W'(4);
      default: begin idx = '0; hit = 1'b0; end
    endcase
  end

  wire accept = fetch_done && !pend_q && !exec_q && !halt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      uaddr_q <= '0;
      buf_q   <= '0;
      pend_q  <= 1'b0;
      exec_q  <= 1'b0;
      halt_q  <= 1'b0;
    end else begin
      pend_q <= accept;
      exec_q <= pend_q;
      if (accept) uaddr_q <= opcode;
      if (pend_q) buf_q <= hit ? ustore[idx] : '0;
      if (exec_q && buf_q[CW_W-1]) halt_q <= 1'b1;
    end
  end

  assign ctrl   = halt_q ? '0 : (exec_q ? buf_q : FETCH_WORD);
  assign halted = halt_q;

  // R4
  exec_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    exec_q |=> !exec_q);
  // R6
  uaddr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_q || exec_q) |=> $stable(uaddr_q));
  // R5
  bad_op_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !hit) |=> (ctrl == '0));
  // R7
  halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    halted |-> (ctrl == '0));
  // R7
  halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);
endmodule

// File: tb/tb_ucode_sequencer.sv
module tb_ucode_sequencer;
  localparam logic [10:0] FW = 11'h01B;
  logic clk = 0, rst = 1, fetch_done = 0;
  logic [3:0] opcode = '0;
  logic [10:0] ctrl;
  logic halted;
  int checks = 0, errors = 0;
  bit halted_m = 0;

  logic [10:0] q_c[$];
  bit          q_h[$];
  string       q_t[$];

  logic [7:0] mem [16];
  logic [7:0] acc = 0, outr = 0;
  logic [3:0] dp_addr = 0;

  ucode_sequencer dut (.clk(clk), .rst(rst), .opcode(opcode),
    .fetch_done(fetch_done), .ctrl(ctrl), .halted(halted));

  always #10 clk = ~clk;

  function automatic logic [10:0] exp_word(input logic [3:0] op);
    case (op)
      4'h0: return 11'h02C;
      4'h1: return 11'h18C;
      4'h2: return 11'h1CC;
      4'hE: return 11'h200;
      4'hF: return 11'h400;
      default: return 11'h000;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [10:0] a, input logic [10:0] e);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, a, e);
    end
  endtask

  task automatic push(input logic [10:0] c, input bit h, input string t);
    q_c.push_back(c); q_h.push_back(h); q_t.push_back(t);
  endtask

  task automatic idle(input string t);
    @(negedge clk);
    fetch_done = 0;
    push(halted_m ? 11'h0 : FW, halted_m, t);
  endtask

  task automatic issue(input logic [3:0] op, input logic [3:0] a, input bit hold, input string t);
    @(negedge clk);
    opcode = op; dp_addr = a; fetch_done = 1;
    push(halted_m ? 11'h0 : FW, halted_m, t);
    @(negedge clk);
    fetch_done = hold;
    opcode = ~op;
    push(halted_m ? 11'h0 : exp_word(op), halted_m, t);
    @(negedge clk);
    fetch_done = hold;
    if (!halted_m && op == 4'hF) halted_m = 1;
    push(halted_m ? 11'h0 : FW, halted_m, t);
  endtask

  // monitor: pop and compare after each rising edge, then run the datapath model
  initial forever begin
    @(posedge clk); #2;
    if (q_c.size() > 0) begin
      logic [10:0] ec; bit eh; string et;
      ec = q_c.pop_front(); eh = q_h.pop_front(); et = q_t.pop_front();
      chk(ctrl == ec && halted == eh, et, {ctrl[9:0], halted}, {ec[9:0], eh});
      if (ctrl[5] && !ctrl[7]) acc = mem[dp_addr];
      if (ctrl[7]) acc = ctrl[6] ? acc - mem[dp_addr] : acc + mem[dp_addr];
      if (ctrl[9]) outr = acc;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 8'h00;
    mem[9] = 8'h10; mem[10] = 8'h14; mem[11] = 8'h18; mem[12] = 8'h20;
    repeat (3) @(negedge clk);
    chk(ctrl == FW && !halted, "R1 in reset", ctrl, FW);
    rst = 0;
    @(negedge clk);
    chk(ctrl == FW && !halted, "R1 after reset", ctrl, FW);
    idle("R2 idle"); idle("R2 idle");
    issue(4'h0, 4'h0, 0, "R3 R4 load");
    issue(4'h1, 4'h0, 0, "R3 R4 add");
    issue(4'h2, 4'h0, 0, "R3 R4 sub");
    issue(4'hE, 4'h0, 0, "R3 R4 out");
    idle("R2 idle");
    issue(4'h5, 4'h0, 0, "R5 op 0101");
    issue(4'h7, 4'h0, 0, "R5 op 0111");
    issue(4'h1, 4'h0, 1, "R6 strobe held");
    issue(4'h2, 4'h0, 1, "R6 strobe held");
    idle("R6 after held");
    @(negedge clk);
    acc = 0; outr = 0;
    issue(4'h0, 4'h9, 0, "R8 lda");
    issue(4'h1, 4'hA, 0, "R8 add");
    issue(4'h1, 4'hB, 0, "R8 add");
    issue(4'h2, 4'hC, 0, "R8 sub");
    issue(4'hE, 4'h0, 0, "R8 out");
    issue(4'hF, 4'h0, 0, "R3 R7 halt");
    idle("R7 halted idle");
    chk(outr == 8'h1C, "R8 result", {3'b0, outr}, 11'h01C);
    issue(4'h0, 4'h9, 0, "R7 strobe ignored");
    idle("R7 halted idle");
    @(negedge clk);
    rst = 1;
    @(negedge clk);
    chk(ctrl == FW && !halted, "R9 reset after halt", {ctrl[9:0], halted}, {FW[9:0], 1'b0});
    halted_m = 0; rst = 0;
    issue(4'h1, 4'h0, 0, "R9 run again");
    idle("R9 idle");
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule